// File: doc/BRIEF.md
# Last-Gasp Log Commit Controller

This block turns an early power-fail warning into one compact, self-describing record in byte-wide non-volatile storage. When the warning arrives it freezes the event sequence number and the first recorded fault cause. It takes a snapshot from telemetry values that were latched before the fault, plus the power-good/reset bitmap sampled in that same cycle. It then streams a fixed-order record through a write/ready memory handshake. While the commit runs, a guard output withholds grants from non-essential bus requesters so that they cannot slow down the commit.

The record always starts by overwriting its marker byte with an invalid code and always ends by writing the valid code. A commit that stops part way therefore never reads as good. A ready line that stalls for too long aborts the commit and reports a partial result. After a later power-up, a boot check reads the marker first, then the body, and verifies the CRC. Only then does it publish the recovered event number, cause and bitmap.

Top module: `lastgasp_commit`

## Requirements
- R1: A high `pf_det_i` in idle or during a boot check starts a commit and captures `evt_id_i` in that cycle. The first cause seen on `cause_vld_i` since reset is kept. A cause offered in the power-fail cycle or later is never accepted, and neither is a second cause.
- R2: The voltage, current and temperature bytes come from registers loaded by `tlm_ld_i` before the power-fail cycle. A load in the power-fail cycle or later is ignored. The PG/reset bitmap is sampled in the power-fail cycle.
- R3: A commit makes exactly 11 writes, in this order. First, 0x00 to BASE. Then BASE+1..BASE+9 receive, in order: 0xC3, event ID, cause (zero-extended), bitmap, voltage, current, temperature, CRC high byte and CRC low byte. Last, 0xA5 to BASE.
- R4: The CRC is CRC-16 with polynomial 0x1021, initial value 0xFFFF, MSB first and no final XOR. It covers the seven bytes at BASE+1..BASE+7.
- R5: `bus_guard_o` is high from the cycle after the power-fail capture until the commit ends. `nes_gnt_o` follows `nes_req_i` only while the guard is low.
- R6: `commit_state_o` reads 0 (invalid) after reset and during a commit, 2 (written) after a full commit and 1 (partial) after an abort. `commit_done_o` pulses for one cycle at the end.
- R7: STALL_LIMIT consecutive not-ready cycles abort the commit. The result is partial, no further write is issued and the stored marker stays 0x00.
- R8: After a commit ends, the block halts until reset. Further power-fail assertions cause no writes and no guard.
- R9: `boot_chk_i` in idle starts a check whose first read is the marker at BASE. A marker other than 0xA5 ends the check at once with `chk_ok_o` low, after only that one read.
- R10: Otherwise the check reads BASE+1..BASE+9 and recomputes the CRC. `chk_ok_o` goes high only on a match, and only then do the `log_*` outputs update. A mismatch, or a read stall of STALL_LIMIT cycles, leaves them unchanged.
- R11: A power-fail takes priority over a boot check, whether both arrive in the same cycle or the warning comes during the check. The check is dropped without `chk_done_o`, and the commit runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_det_i | input | 1 | Early power-fail warning |
| evt_id_i | input | 8 | Running event sequence number |
| cause_vld_i | input | 1 | Fault cause strobe |
| cause_i | input | CAUSE_W | Fault cause code |
| pg_map_i | input | 8 | Live power-good/reset bitmap |
| tlm_ld_i | input | 1 | Telemetry latch strobe |
| volt_i | input | 8 | Voltage reading |
| curr_i | input | 8 | Current reading |
| temp_i | input | 8 | Temperature reading |
| nes_req_i | input | 1 | Non-essential bus request |
| nes_gnt_o | output | 1 | Non-essential bus grant |
| bus_guard_o | output | 1 | Bus traffic guard active |
| mem_we_o | output | 1 | Memory write request |
| mem_re_o | output | 1 | Memory read request |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | 8 | Memory write byte |
| mem_rdata_i | input | 8 | Memory read byte, valid with ready |
| mem_rdy_i | input | 1 | Memory accepts the current request |
| commit_state_o | output | 2 | Commit result code |
| commit_done_o | output | 1 | Commit end pulse |
| boot_chk_i | input | 1 | Start record validation |
| chk_done_o | output | 1 | Validation end pulse |
| chk_ok_o | output | 1 | Record found intact |
| log_evt_o | output | 8 | Recovered event ID |
| log_cause_o | output | CAUSE_W | Recovered first cause |
| log_pg_o | output | 8 | Recovered bitmap |

## Verification
The risky coincidence is a power-fail warning that lands while the boot check is active. The bench raises `pf_det_i` and `boot_chk_i` in the same cycle, and separately raises the warning three cycles into a running check. In both cases it expects a complete, correctly ordered record and no `chk_done_o` pulse. A second coincidence places a new cause strobe, a telemetry load and a bitmap change in the power-fail cycle itself. The bench then expects the stored bytes to hold only the values from before that cycle.

// File: rtl/lastgasp_commit.sv
module lastgasp_commit #(
  parameter int CAUSE_W = 4,
  parameter int AW = 8,
  parameter logic [AW-1:0] BASE = '0,
  parameter int STALL_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pf_det_i,
  input  logic [7:0]         evt_id_i,
  input  logic               cause_vld_i,
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic [7:0]         pg_map_i,
  input  logic               tlm_ld_i,
  input  logic [7:0]         volt_i,
  input  logic [7:0]         curr_i,
  input  logic [7:0]         temp_i,
  input  logic               nes_req_i,
  output logic               nes_gnt_o,
  output logic               bus_guard_o,
  output logic               mem_we_o,
  output logic               mem_re_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [7:0]         mem_wdata_o,
  input  logic [7:0]         mem_rdata_i,
  input  logic               mem_rdy_i,
  output logic [1:0]         commit_state_o,
  output logic               commit_done_o,
  input  logic               boot_chk_i,
  output logic               chk_done_o,
  output logic               chk_ok_o,
  output logic [7:0]         log_evt_o,
  output logic [CAUSE_W-1:0] log_cause_o,
  output logic [7:0]         log_pg_o
);

  localparam int TW = $clog2(STALL_LIMIT + 1);
  localparam logic [7:0] MK_VALID = 8'hA5;
  localparam logic [7:0] MK_INVALID = 8'h00;
  localparam logic [7:0] HDR_TAG = 8'hC3;
  localparam logic [3:0] LAST_W = 4'd10;
  localparam logic [1:0] CS_INVALID = 2'd0;
  localparam logic [1:0] CS_PARTIAL = 2'd1;
  localparam logic [1:0] CS_WRITTEN = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_WR, S_RD, S_HALT} st_t;

  st_t st;
  logic [3:0] idx;
  logic [TW-1:0] tmr;
  logic [7:0] evt_q, pg_q, v_q, i_q, t_q, crc_hi_q;
  logic [CAUSE_W-1:0] cause_q, rd_cause;
  logic cause_have, crc_sent;
  logic [15:0] crc_q;
  logic [1:0] cs_q;
  logic done_q, chk_done_q, chk_ok_q;
  logic [7:0] rd_evt, rd_pg;
  logic [7:0] log_evt_q, log_pg_q;
  logic [CAUSE_W-1:0] log_cause_q;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int b = 0; b < 8; b++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    return r;
  endfunction

  wire unlocked = (st == S_IDLE) || (st == S_RD);
  wire locked = !unlocked;
  wire pf_go = pf_det_i && unlocked;
  wire active = (st == S_WR) || (st == S_RD);
  wire stall = active && !mem_rdy_i;
  wire abort = stall && (tmr == TW'(STALL_LIMIT - 1));
  wire body = (idx >= 4'd1) && (idx <= 4'd7);

  assign bus_guard_o = (st == S_WR);
  assign nes_gnt_o = nes_req_i && !bus_guard_o;
  assign mem_we_o = (st == S_WR);
  assign mem_re_o = (st == S_RD);
  assign mem_addr_o = (idx == 4'd0 || idx == LAST_W) ? BASE : BASE + AW'(idx);
  assign commit_state_o = cs_q;
  assign commit_done_o = done_q;
  assign chk_done_o = chk_done_q;
  assign chk_ok_o = chk_ok_q;
  assign log_evt_o = log_evt_q;
  assign log_cause_o = log_cause_q;
  assign log_pg_o = log_pg_q;

  always_comb begin
    case (idx)
      4'd0: mem_wdata_o = MK_INVALID;
      4'd1: mem_wdata_o = HDR_TAG;
      4'd2: mem_wdata_o = evt_q;
      4'd3: mem_wdata_o = 8'(cause_q);
      4'd4: mem_wdata_o = pg_q;
      4'd5: mem_wdata_o = v_q;
      4'd6: mem_wdata_o = i_q;
      4'd7: mem_wdata_o = t_q;
      4'd8: mem_wdata_o = crc_q[15:8];
      4'd9: mem_wdata_o = crc_q[7:0];
      default: mem_wdata_o = MK_VALID;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      idx <= '0;
      tmr <= '0;
      evt_q <= '0;
      pg_q <= '0;
      v_q <= '0;
      i_q <= '0;
      t_q <= '0;
      crc_hi_q <= '0;
      cause_q <= '0;
      cause_have <= 1'b0;
      crc_sent <= 1'b0;
      crc_q <= 16'hFFFF;
      cs_q <= CS_INVALID;
      done_q <= 1'b0;
      chk_done_q <= 1'b0;
      chk_ok_q <= 1'b0;
      rd_evt <= '0;
      rd_cause <= '0;
      rd_pg <= '0;
      log_evt_q <= '0;
      log_cause_q <= '0;
      log_pg_q <= '0;
    end else begin
      done_q <= 1'b0;
      chk_done_q <= 1'b0;
      tmr <= stall ? tmr + 1'b1 : '0;
      if (unlocked && !pf_det_i && cause_vld_i && !cause_have) begin
        cause_q <= cause_i;
        cause_have <= 1'b1;
      end
      if (unlocked && !pf_det_i && tlm_ld_i) begin
        v_q <= volt_i;
        i_q <= curr_i;
        t_q <= temp_i;
      end
      if (pf_go) begin
        evt_q <= evt_id_i;
        pg_q <= pg_map_i;
        st <= S_WR;
        idx <= '0;
        tmr <= '0;
        crc_q <= 16'hFFFF;
        crc_sent <= 1'b0;
        cs_q <= CS_INVALID;
      end else begin
        case (st)
          S_IDLE: if (boot_chk_i) begin
            st <= S_RD;
            idx <= '0;
            crc_q <= 16'hFFFF;
            chk_ok_q <= 1'b0;
          end
          S_WR: if (abort) begin
            cs_q <= CS_PARTIAL;
            done_q <= 1'b1;
            st <= S_HALT;
          end else if (mem_rdy_i) begin
            if (body) crc_q <= crc_step(crc_q, mem_wdata_o);
            if (idx == 4'd9) crc_sent <= 1'b1;
            if (idx == LAST_W) begin
              cs_q <= CS_WRITTEN;
              done_q <= 1'b1;
              st <= S_HALT;
            end else idx <= idx + 4'd1;
          end
          S_RD: if (abort) begin
            chk_done_q <= 1'b1;
            chk_ok_q <= 1'b0;
            st <= S_IDLE;
          end else if (mem_rdy_i) begin
            idx <= idx + 4'd1;
            if (body) crc_q <= crc_step(crc_q, mem_rdata_i);
            if (idx == 4'd2) rd_evt <= mem_rdata_i;
            if (idx == 4'd3) rd_cause <= mem_rdata_i[CAUSE_W-1:0];
            if (idx == 4'd4) rd_pg <= mem_rdata_i;
            if (idx == 4'd8) crc_hi_q <= mem_rdata_i;
            if (idx == 4'd0 && mem_rdata_i != MK_VALID) begin
              chk_done_q <= 1'b1;
              chk_ok_q <= 1'b0;
              st <= S_IDLE;
            end
            if (idx == 4'd9) begin
              chk_done_q <= 1'b1;
              st <= S_IDLE;
              if ({crc_hi_q, mem_rdata_i} == crc_q) begin
                chk_ok_q <= 1'b1;
                log_evt_q <= rd_evt;
                log_cause_q <= rd_cause;
                log_pg_q <= rd_pg;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_evt_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR && $past(st) == S_WR) |-> $stable(evt_q));
  p_cause_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable(cause_q));
  p_snap_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && $past(locked)) |-> $stable({v_q, i_q, t_q, pg_q}));
  p_valid_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && mem_addr_o == BASE && mem_wdata_o == MK_VALID) |-> crc_sent);
  p_grant_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    nes_gnt_o |-> !mem_we_o);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_done_o |=> !commit_done_o);
  p_partial_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_q == CS_PARTIAL) |-> !mem_we_o);
  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(st) == S_HALT) |-> (st == S_HALT));
  p_log_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(log_evt_o) |-> chk_ok_o);

endmodule

// File: tb/lastgasp_commit_tb_top.sv
`timescale 1ns/1ps
module lastgasp_commit_tb_top;
  localparam int CW = 4;
  localparam int AW = 8;
  localparam logic [7:0] BASE = 8'h10;
  localparam int SL = 16;

  localparam logic [47:0] VEC [4] = '{
    48'h01_03_FF_7A_2C_41,
    48'h80_0F_00_00_00_00,
    48'hFE_01_A5_C3_A5_FF,
    48'h3C_09_5A_12_34_56
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic pf_det = 0, cause_vld = 0, tlm_ld = 0, nes_req = 0, boot_chk = 0;
  logic [7:0] evt_id = 0, pg_map = 0, volt = 0, curr = 0, temp = 0;
  logic [CW-1:0] cause = 0;
  logic nes_gnt, guard, mem_we, mem_re, mem_rdy, done, chk_done, chk_ok;
  logic [AW-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata, log_evt, log_pg;
  logic [1:0] cs;
  logic [CW-1:0] log_cause;

  logic [7:0] mem [0:255];
  logic [15:0] wlog [0:31];
  int wr_cnt = 0, rd_cnt = 0, chk_cnt = 0, stall_at = 1000;
  logic clr = 0, corrupt = 0, rdy_en = 1;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign mem_rdy = rdy_en && (wr_cnt < stall_at);
  assign mem_rdata = mem[mem_addr] ^ ((corrupt && mem_addr == BASE + 8'd5) ? 8'h01 : 8'h00);

  always @(posedge clk) begin
    if (clr) begin
      wr_cnt <= 0; rd_cnt <= 0; chk_cnt <= 0;
    end else begin
      if (mem_we && mem_rdy) begin
        mem[mem_addr] <= mem_wdata;
        if (wr_cnt < 32) wlog[wr_cnt] <= {mem_addr, mem_wdata};
        wr_cnt <= wr_cnt + 1;
      end
      if (mem_re && mem_rdy) rd_cnt <= rd_cnt + 1;
      if (chk_done) chk_cnt <= chk_cnt + 1;
    end
  end

  lastgasp_commit #(.CAUSE_W(CW), .AW(AW), .BASE(BASE), .STALL_LIMIT(SL)) dut_i (
    .clk(clk), .rst_n(rst_n), .pf_det_i(pf_det), .evt_id_i(evt_id),
    .cause_vld_i(cause_vld), .cause_i(cause), .pg_map_i(pg_map), .tlm_ld_i(tlm_ld),
    .volt_i(volt), .curr_i(curr), .temp_i(temp), .nes_req_i(nes_req), .nes_gnt_o(nes_gnt),
    .bus_guard_o(guard), .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_rdy_i(mem_rdy),
    .commit_state_o(cs), .commit_done_o(done), .boot_chk_i(boot_chk),
    .chk_done_o(chk_done), .chk_ok_o(chk_ok), .log_evt_o(log_evt),
    .log_cause_o(log_cause), .log_pg_o(log_pg));

  function automatic logic [15:0] crc16(input logic [7:0] b [7]);
    logic [15:0] r = 16'hFFFF;
    for (int k = 0; k < 7; k++) begin
      r = r ^ {b[k], 8'h00};
      for (int j = 0; j < 8; j++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; pf_det = 0; boot_chk = 0; cause_vld = 0; tlm_ld = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic clear_counts();
    clr = 1; @(negedge clk); clr = 0;
  endtask

  task automatic wait_done(output bit got);
    got = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (done) begin got = 1; break; end
    end
  endtask

  task automatic wait_chk(output bit got);
    got = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (chk_done) begin got = 1; break; end
    end
  endtask

  task automatic preload(input logic [7:0] c, input logic [7:0] v, input logic [7:0] i, input logic [7:0] t);
    @(negedge clk);
    cause_vld = 1; cause = c[CW-1:0]; tlm_ld = 1; volt = v; curr = i; temp = t;
    @(negedge clk);
    cause_vld = 0; tlm_ld = 0;
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    bit got;
    logic [7:0] body [7];
    logic [15:0] crc;
    logic [7:0] e_evt, e_pg;

    do_reset();
    nes_req = 1;
    @(negedge clk);
    check("R6 reset state", cs, 0);
    check("R5 guard idle", guard, 0);
    check("R5 grant idle", nes_gnt, 1);
    check("R10 reset ok", chk_ok, 0);
    check("R3 no write at reset", mem_we, 0);

    for (int n = 0; n < 4; n++) begin
      do_reset();
      clear_counts();
      preload(VEC[n][39:32], VEC[n][23:16], VEC[n][15:8], VEC[n][7:0]);
      @(negedge clk);
      pf_det = 1; evt_id = VEC[n][47:40]; pg_map = VEC[n][31:24];
      @(negedge clk);
      pf_det = 0;
      check("R5 guard on", guard, 1);
      check("R5 grant blocked", nes_gnt, 0);
      wait_done(got);
      check("R6 done seen", got, 1);
      check("R6 written", cs, 2);
      body[0] = 8'hC3; body[1] = VEC[n][47:40]; body[2] = {4'h0, VEC[n][35:32]};
      body[3] = VEC[n][31:24]; body[4] = VEC[n][23:16]; body[5] = VEC[n][15:8]; body[6] = VEC[n][7:0];
      crc = crc16(body);
      @(negedge clk);
      check("R5 guard off", guard, 0);
      check("R3 write count", wr_cnt, 11);
      check("R3 marker cleared first", wlog[0], {BASE, 8'h00});
      for (int k = 0; k < 7; k++) check("R3 body byte", wlog[k+1], {BASE + 8'(k + 1), body[k]});
      check("R4 crc hi", wlog[8], {BASE + 8'd8, crc[15:8]});
      check("R4 crc lo", wlog[9], {BASE + 8'd9, crc[7:0]});
      check("R3 valid last", wlog[10], {BASE, 8'hA5});
      do_reset();
      clear_counts();
      boot_chk = 1; @(negedge clk); boot_chk = 0;
      wait_chk(got);
      check("R10 chk done", got, 1);
      check("R10 chk ok", chk_ok, 1);
      check("R10 log evt", log_evt, VEC[n][47:40]);
      check("R10 log cause", log_cause, VEC[n][35:32]);
      check("R10 log pg", log_pg, VEC[n][31:24]);
      check("R9 read count", rd_cnt, 10);
    end

    clear_counts();
    corrupt = 1;
    boot_chk = 1; @(negedge clk); boot_chk = 0;
    wait_chk(got);
    corrupt = 0;
    check("R10 bad crc rejected", chk_ok, 0);
    check("R10 log held", log_evt, 8'h3C);
    check("R10 read count", rd_cnt, 10);

    do_reset();
    clear_counts();
    preload(8'h05, 8'h11, 8'h22, 8'h33);
    @(negedge clk); cause_vld = 1; cause = 4'h9; @(negedge clk); cause_vld = 0;
    @(negedge clk);
    pf_det = 1; evt_id = 8'h42; pg_map = 8'h81; cause_vld = 1; cause = 4'h7;
    tlm_ld = 1; volt = 8'hEE; curr = 8'hEE; temp = 8'hEE;
    @(negedge clk);
    pf_det = 0; evt_id = 8'h43; pg_map = 8'h00; cause = 4'h2; volt = 8'hDD;
    @(negedge clk);
    cause_vld = 0; tlm_ld = 0;
    wait_done(got);
    check("R1 evt frozen", mem[BASE + 8'd2], 8'h42);
    check("R1 first cause", mem[BASE + 8'd3], 8'h05);
    check("R2 pg at pf", mem[BASE + 8'd4], 8'h81);
    check("R2 volt pre-fault", mem[BASE + 8'd5], 8'h11);
    check("R2 temp pre-fault", mem[BASE + 8'd7], 8'h33);

    clear_counts();
    pf_det = 1;
    repeat (5) @(negedge clk);
    pf_det = 0;
    check("R8 no rewrite", wr_cnt, 0);
    check("R8 no guard", guard, 0);

    do_reset();
    clear_counts();
    stall_at = 4;
    preload(8'h03, 8'h01, 8'h02, 8'h03);
    @(negedge clk); pf_det = 1; @(negedge clk); pf_det = 0;
    wait_done(got);
    check("R7 abort done", got, 1);
    check("R7 partial", cs, 1);
    check("R7 writes stopped", wr_cnt, 4);
    check("R7 marker invalid", mem[BASE], 8'h00);
    repeat (3) @(negedge clk);
    check("R7 no later write", wr_cnt, 4);
    stall_at = 1000;
    do_reset();
    clear_counts();
    boot_chk = 1; @(negedge clk); boot_chk = 0;
    wait_chk(got);
    check("R9 invalid marker", chk_ok, 0);
    check("R9 single read", rd_cnt, 1);

    do_reset();
    clear_counts();
    @(negedge clk);
    pf_det = 1; boot_chk = 1; evt_id = 8'h77;
    @(negedge clk);
    pf_det = 0; boot_chk = 0;
    wait_done(got);
    check("R11 same-cycle written", cs, 2);
    check("R11 no chk done", chk_cnt, 0);
    check("R11 evt", mem[BASE + 8'd2], 8'h77);

    do_reset();
    clear_counts();
    boot_chk = 1; @(negedge clk); boot_chk = 0;
    repeat (3) @(negedge clk);
    pf_det = 1; evt_id = 8'h99; @(negedge clk); pf_det = 0;
    wait_done(got);
    check("R11 mid-check written", cs, 2);
    check("R11 mid-check no chk done", chk_cnt, 0);
    check("R11 mid-check marker", mem[BASE], 8'hA5);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule